// File: doc/BRIEF.md
# Inter-processor doorbell unit

The doorbell unit lets processors on a chip signal one another without passing any data. Each of its doorbells is rung by a bus write that carries the writer's master ID, and it remembers which masters rang it. A per-doorbell permission mask selects which masters may raise the doorbell's interrupt. Every doorbell drives one level-sensitive interrupt line. That line stays high until the receiving side acknowledges each requester by clearing its bit.

Software reaches the unit through a simple memory-mapped write/read bus. The number of bus ports is a parameter, two by default, so two agents can act on the unit in the same clock. Each port carries its own master ID sideband and has its own read-data register.

Top module: `db_doorbell_unit`

## Requirements
- R1: After reset every permission, attempt-log and pending register reads zero, all interrupt lines are low and every read-data output is zero.
- R2: Doorbell d occupies the window starting at d*0x100. Inside a window, offset 0x0 is the ring register, 0x4 the permission mask, 0x8 the attempt log and 0xC the pending register. A read returns its value on that port's read data after the clock edge that accepts it, and the ring register reads as zero. An access to a doorbell index at or above the doorbell count, or to any other offset, changes nothing, and a read of it returns zero.
- R3: A write of a word with bit 0 set to the ring register sets the attempt-log bit whose index equals the writing port's master ID, whatever the permission mask holds. A ring write with bit 0 clear has no effect.
- R4: A ring sets the pending bit for master m only if bit m of the permission mask was set before the cycle of the ring.
- R5: The permission mask is written and read as a whole word. Clearing mask bits does not remove pending bits that are already set.
- R6: The attempt log and the pending register are write-one-to-clear. Each 1 in the written word clears that bit, and each 0 leaves it unchanged.
- R7: When one port rings master m while another port clears bit m of the pending register or the attempt log in the same cycle, the bit stays set.
- R8: Interrupt line d is high exactly when the pending register of doorbell d is non-zero, and it follows that register from the clock edge that accepts the write.
- R9: Rings from several ports in one cycle set the bits of all their master IDs. When several ports write one permission mask in the same cycle, the highest-numbered port's value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | NUM_PORTS | Access request, one bit per port |
| bus_we | input | NUM_PORTS | 1 = write, 0 = read, per port |
| bus_addr | input | NUM_PORTS x ADDR_W | Byte address per port |
| bus_wdata | input | NUM_PORTS x NUM_MASTERS | Write data per port |
| bus_mid | input | NUM_PORTS x log2(NUM_MASTERS) | Master ID of the requester per port |
| bus_rdata | output | NUM_PORTS x NUM_MASTERS | Registered read data per port |
| db_irq | output | NUM_DB | Level interrupt per doorbell |

## Verification
Two ports can reach the same doorbell in one clock, so a ring and an acknowledge-clear of the same master's bit can fall together. The bench provokes this by driving port 0 with a ring and port 1 with a write-one-to-clear on the same negative edge. It does this once against the pending register and once against the attempt log. It then reads back and expects the bit still set, with the interrupt still high, while a lone clear issued later must empty the register. A concurrent pair of rings from different masters and a concurrent pair of mask writes are judged in the same way, against the union of the bits and against the highest-numbered port's value.

// File: rtl/db_pkg.sv
package db_pkg;

    // Register selector taken from address bits [3:2] inside a window
    typedef enum logic [1:0] {
        REG_RING = 2'd0,
        REG_PERM = 2'd1,
        REG_LOG  = 2'd2,
        REG_PEND = 2'd3
    } db_reg_e;

    // log2 of the byte spacing between doorbell windows
    localparam int WIN_LG2 = 8;

endpackage

// File: rtl/db_addr_decode.sv
module db_addr_decode
    import db_pkg::*;
#(
    parameter int NUM_DB = 8,
    parameter int ADDR_W = 12
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NUM_DB-1:0] hit_o,
    output logic [1:0]        sel_o
);

    localparam int IDX_W = ADDR_W - WIN_LG2;

    logic [IDX_W-1:0] idx;
    logic             aligned;

    assign idx     = addr_i[ADDR_W-1:WIN_LG2];
    assign aligned = (addr_i[WIN_LG2-1:4] == '0) && (addr_i[1:0] == 2'b00);
    assign sel_o   = addr_i[3:2];

    // One window per doorbell; an index past the last doorbell hits nothing
    for (genvar d = 0; d < NUM_DB; d++) begin : g_hit
        assign hit_o[d] = valid_i && aligned && (32'(idx) == d);
    end

endmodule

// File: rtl/db_cell.sv
module db_cell
    import db_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 32,
    parameter int MID_W     = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PORTS-1:0]             wr_hit_i,
    input  logic [NUM_PORTS-1:0][1:0]        sel_i,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_i,
    input  logic [NUM_PORTS-1:0][MID_W-1:0]  mid_i,
    output logic [DATA_W-1:0]                perm_o,
    output logic [DATA_W-1:0]                log_o,
    output logic [DATA_W-1:0]                pend_o,
    output logic [DATA_W-1:0]                ring_o,
    output logic                             ring_any_o,
    output logic                             pclr_any_o
);

    typedef struct packed {
        logic [DATA_W-1:0] perm;
        logic [DATA_W-1:0] log;
        logic [DATA_W-1:0] pend;
    } cell_st_t;

    cell_st_t st_d, st_q;

    logic [DATA_W-1:0] set_v;
    logic [DATA_W-1:0] log_clr;
    logic [DATA_W-1:0] pend_clr;
    logic [DATA_W-1:0] perm_n;
    logic              pclr_any;

    always_comb begin
        set_v    = '0;
        log_clr  = '0;
        pend_clr = '0;
        pclr_any = 1'b0;
        perm_n   = st_q.perm;
        // Ascending port order: the last matching mask write is kept
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr_hit_i[p]) begin
                unique case (db_reg_e'(sel_i[p]))
                    REG_RING: begin
                        if (wdata_i[p][0]) begin
                            set_v[mid_i[p]] = 1'b1;
                        end
                    end
                    REG_PERM: perm_n = wdata_i[p];
                    REG_LOG:  log_clr = log_clr | wdata_i[p];
                    REG_PEND: begin
                        pend_clr = pend_clr | wdata_i[p];
                        pclr_any = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
        st_d.perm = perm_n;
        // A ring in the same cycle as a clear wins
        st_d.log  = (st_q.log & ~log_clr) | set_v;
        st_d.pend = (st_q.pend & ~pend_clr) | (set_v & st_q.perm);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign perm_o     = st_q.perm;
    assign log_o      = st_q.log;
    assign pend_o     = st_q.pend;
    assign ring_o     = set_v & st_q.perm;
    assign ring_any_o = |set_v;
    assign pclr_any_o = pclr_any;

endmodule

// File: rtl/db_read_port.sv
module db_read_port
    import db_pkg::*;
#(
    parameter int NUM_DB = 8,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_req_i,
    input  logic [NUM_DB-1:0]             hit_i,
    input  logic [1:0]                    sel_i,
    input  logic [NUM_DB-1:0][DATA_W-1:0] perm_i,
    input  logic [NUM_DB-1:0][DATA_W-1:0] log_i,
    input  logic [NUM_DB-1:0][DATA_W-1:0] pend_i,
    output logic [DATA_W-1:0]             rdata_o
);

    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic [DATA_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int d = 0; d < NUM_DB; d++) begin
            if (hit_i[d]) begin
                unique case (db_reg_e'(sel_i))
                    REG_PERM: pick = perm_i[d];
                    REG_LOG:  pick = log_i[d];
                    REG_PEND: pick = pend_i[d];
                    default:  pick = '0;
                endcase
            end
        end
        rdata_d = rd_req_i ? pick : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/db_doorbell_unit.sv
module db_doorbell_unit #(
    parameter int NUM_DB      = 8,
    parameter int NUM_PORTS   = 2,
    parameter int NUM_MASTERS = 32,
    parameter int ADDR_W      = 12
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic [NUM_PORTS-1:0]                                bus_valid,
    input  logic [NUM_PORTS-1:0]                                bus_we,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]                    bus_addr,
    input  logic [NUM_PORTS-1:0][NUM_MASTERS-1:0]               bus_wdata,
    input  logic [NUM_PORTS-1:0][$clog2(NUM_MASTERS)-1:0]       bus_mid,
    output logic [NUM_PORTS-1:0][NUM_MASTERS-1:0]               bus_rdata,
    output logic [NUM_DB-1:0]                                   db_irq
);

    localparam int DATA_W = NUM_MASTERS;
    localparam int MID_W  = $clog2(NUM_MASTERS);

    logic [NUM_PORTS-1:0][NUM_DB-1:0] port_hit;
    logic [NUM_PORTS-1:0][1:0]        port_sel;
    logic [NUM_DB-1:0][NUM_PORTS-1:0] cell_wr;

    logic [NUM_DB-1:0][DATA_W-1:0] perm_all;
    logic [NUM_DB-1:0][DATA_W-1:0] log_all;
    logic [NUM_DB-1:0][DATA_W-1:0] pend_all;
    logic [NUM_DB-1:0][DATA_W-1:0] ring_all;
    logic [NUM_DB-1:0]             ring_any;
    logic [NUM_DB-1:0]             pclr_any;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        db_addr_decode #(
            .NUM_DB (NUM_DB),
            .ADDR_W (ADDR_W)
        ) dec_i (
            .valid_i (bus_valid[p]),
            .addr_i  (bus_addr[p]),
            .hit_o   (port_hit[p]),
            .sel_o   (port_sel[p])
        );

        db_read_port #(
            .NUM_DB (NUM_DB),
            .DATA_W (DATA_W)
        ) rd_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_req_i (bus_valid[p] && !bus_we[p]),
            .hit_i    (port_hit[p]),
            .sel_i    (port_sel[p]),
            .perm_i   (perm_all),
            .log_i    (log_all),
            .pend_i   (pend_all),
            .rdata_o  (bus_rdata[p])
        );
    end

    // Regroup write hits from per-port to per-doorbell
    always_comb begin
        for (int d = 0; d < NUM_DB; d++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                cell_wr[d][p] = port_hit[p][d] && bus_we[p];
            end
        end
    end

    for (genvar d = 0; d < NUM_DB; d++) begin : g_db
        db_cell #(
            .NUM_PORTS (NUM_PORTS),
            .DATA_W    (DATA_W),
            .MID_W     (MID_W)
        ) cell_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_hit_i   (cell_wr[d]),
            .sel_i      (port_sel),
            .wdata_i    (bus_wdata),
            .mid_i      (bus_mid),
            .perm_o     (perm_all[d]),
            .log_o      (log_all[d]),
            .pend_o     (pend_all[d]),
            .ring_o     (ring_all[d]),
            .ring_any_o (ring_any[d]),
            .pclr_any_o (pclr_any[d])
        );

        assign db_irq[d] = |pend_all[d];
    end

endmodule

// File: rtl/db_doorbell_unit_chk.sv
module db_doorbell_unit_chk #(
    parameter int NUM_DB = 8,
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_DB-1:0]             db_irq,
    input logic [NUM_DB-1:0][DATA_W-1:0] pend_all,
    input logic [NUM_DB-1:0][DATA_W-1:0] perm_all,
    input logic [NUM_DB-1:0][DATA_W-1:0] ring_all,
    input logic [NUM_DB-1:0]             ring_any,
    input logic [NUM_DB-1:0]             pclr_any
);

    p_irq_clear_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (db_irq == '0));

    for (genvar d = 0; d < NUM_DB; d++) begin : g_chk
        p_pend_needs_perm_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_all[d] & ~$past(pend_all[d]) & ~$past(perm_all[d])) == '0);

        p_ring_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(ring_all[d]) & ~pend_all[d]) == '0);

        p_irq_rise_on_ring_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(db_irq[d]) |-> $past(ring_any[d]));

        p_irq_fall_on_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(db_irq[d]) |-> $past(pclr_any[d]));
    end

endmodule

bind db_doorbell_unit db_doorbell_unit_chk #(
    .NUM_DB (NUM_DB),
    .DATA_W (DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .db_irq   (db_irq),
    .pend_all (pend_all),
    .perm_all (perm_all),
    .ring_all (ring_all),
    .ring_any (ring_any),
    .pclr_any (pclr_any)
);

// File: tb/db_doorbell_unit_tb_top.sv
`timescale 1ns/1ps
module db_doorbell_unit_tb_top;

    localparam int NDB = 8;
    localparam int NP  = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NP-1:0]        bus_valid = '0;
    logic [NP-1:0]        bus_we = '0;
    logic [NP-1:0][11:0]  bus_addr = '0;
    logic [NP-1:0][31:0]  bus_wdata = '0;
    logic [NP-1:0][4:0]   bus_mid = '0;
    logic [NP-1:0][31:0]  bus_rdata;
    logic [NDB-1:0]       db_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    db_doorbell_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_mid   (bus_mid),
        .bus_rdata (bus_rdata),
        .db_irq    (db_irq)
    );

    typedef struct packed {
        logic [15:0] tag;
        logic        wr;
        logic        port;
        logic [11:0] addr;
        logic [31:0] data;
        logic [4:0]  mid;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{"R5", 1'b1, 1'b0, 12'h204, 32'h0000_0005, 5'd0,  32'h0},          // mask = masters 0,2
        '{"R5", 1'b0, 1'b0, 12'h204, 32'h0,         5'd0,  32'h0000_0005},
        '{"R3", 1'b1, 1'b0, 12'h200, 32'h1,         5'd2,  32'h0},          // permitted ring
        '{"R3", 1'b1, 1'b0, 12'h200, 32'h1,         5'd3,  32'h0},          // ring not permitted
        '{"R3", 1'b1, 1'b1, 12'h200, 32'h0,         5'd0,  32'h0},          // bit0 clear: no ring
        '{"R3", 1'b0, 1'b0, 12'h208, 32'h0,         5'd0,  32'h0000_000C},
        '{"R4", 1'b0, 1'b1, 12'h20C, 32'h0,         5'd0,  32'h0000_0004},
        '{"R2", 1'b0, 1'b0, 12'h200, 32'h0,         5'd0,  32'h0},          // ring reg reads 0
        '{"R6", 1'b1, 1'b0, 12'h208, 32'h0000_0008, 5'd0,  32'h0},
        '{"R6", 1'b0, 1'b0, 12'h208, 32'h0,         5'd0,  32'h0000_0004},
        '{"R5", 1'b1, 1'b0, 12'h204, 32'h0,         5'd0,  32'h0},          // drop the mask
        '{"R5", 1'b0, 1'b0, 12'h20C, 32'h0,         5'd0,  32'h0000_0004},
        '{"R6", 1'b1, 1'b1, 12'h20C, 32'h0000_0004, 5'd0,  32'h0},
        '{"R6", 1'b0, 1'b0, 12'h20C, 32'h0,         5'd0,  32'h0},
        '{"R2", 1'b1, 1'b0, 12'h700, 32'h1,         5'd31, 32'h0},          // last window
        '{"R2", 1'b0, 1'b1, 12'h708, 32'h0,         5'd0,  32'h8000_0000},
        '{"R2", 1'b0, 1'b0, 12'h70C, 32'h0,         5'd0,  32'h0},
        '{"R2", 1'b0, 1'b0, 12'h210, 32'h0,         5'd0,  32'h0}           // unused offset
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negative edge; returns at the next one, after the accepting edge
    task automatic op1(input int p, input bit w, input logic [11:0] a,
                       input logic [31:0] dd, input logic [4:0] m);
        bus_valid[p] = 1'b1;
        bus_we[p]    = w;
        bus_addr[p]  = a;
        bus_wdata[p] = dd;
        bus_mid[p]   = m;
        @(negedge clk);
        bus_valid[p] = 1'b0;
        bus_we[p]    = 1'b0;
    endtask

    task automatic op2(input logic [11:0] a0, input logic [31:0] d0, input logic [4:0] m0,
                       input logic [11:0] a1, input logic [31:0] d1, input logic [4:0] m1);
        bus_valid    = 2'b11;
        bus_we       = 2'b11;
        bus_addr[0]  = a0;
        bus_wdata[0] = d0;
        bus_mid[0]   = m0;
        bus_addr[1]  = a1;
        bus_wdata[1] = d1;
        bus_mid[1]   = m1;
        @(negedge clk);
        bus_valid = 2'b00;
        bus_we    = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(db_irq), 32'h0);
        check("R1 rdata0", bus_rdata[0], 32'h0);
        check("R1 rdata1", bus_rdata[1], 32'h0);
        op1(0, 1'b0, 12'h00C, 32'h0, 5'd0);
        check("R1 pend", bus_rdata[0], 32'h0);
        op1(1, 1'b0, 12'h604, 32'h0, 5'd0);
        check("R1 perm", bus_rdata[1], 32'h0);

        // Table of accesses
        for (int i = 0; i < NV; i++) begin
            op1(int'(TBL[i].port), TBL[i].wr, TBL[i].addr, TBL[i].data, TBL[i].mid);
            if (!TBL[i].wr) begin
                check($sformatf("%s vec%0d", TBL[i].tag, i), bus_rdata[TBL[i].port], TBL[i].exp);
            end
        end

        // R8 interrupt follows pending
        check("R8 idle", 32'(db_irq), 32'h0);
        op1(1, 1'b1, 12'h504, 32'h2, 5'd0);
        check("R8 mask only", 32'(db_irq), 32'h0);
        op1(0, 1'b1, 12'h500, 32'h1, 5'd1);
        check("R8 rise", 32'(db_irq), 32'h20);
        op1(0, 1'b1, 12'h50C, 32'h2, 5'd0);
        check("R8 fall", 32'(db_irq), 32'h0);

        // R7 ring and clear in the same cycle
        op1(0, 1'b1, 12'h404, 32'h40, 5'd0);
        op1(0, 1'b1, 12'h400, 32'h1, 5'd6);
        check("R7 setup irq", 32'(db_irq), 32'h10);
        op2(12'h400, 32'h1, 5'd6, 12'h40C, 32'h40, 5'd0);
        check("R7 irq held", 32'(db_irq), 32'h10);
        op1(0, 1'b0, 12'h40C, 32'h0, 5'd0);
        check("R7 pend held", bus_rdata[0], 32'h40);
        op2(12'h400, 32'h1, 5'd6, 12'h408, 32'h40, 5'd0);
        op1(0, 1'b0, 12'h408, 32'h0, 5'd0);
        check("R7 log held", bus_rdata[0], 32'h40);
        op1(1, 1'b1, 12'h40C, 32'h40, 5'd0);
        op1(1, 1'b0, 12'h40C, 32'h0, 5'd0);
        check("R6 lone clear", bus_rdata[1], 32'h0);
        check("R6 irq low", 32'(db_irq), 32'h0);

        // R9 concurrent rings and mask writes
        op1(0, 1'b1, 12'h304, 32'hFFFF_FFFF, 5'd0);
        op2(12'h300, 32'h1, 5'd1, 12'h300, 32'h1, 5'd9);
        op1(0, 1'b0, 12'h308, 32'h0, 5'd0);
        check("R9 log union", bus_rdata[0], 32'h0000_0202);
        op1(1, 1'b0, 12'h30C, 32'h0, 5'd0);
        check("R9 pend union", bus_rdata[1], 32'h0000_0202);
        op2(12'h304, 32'h11, 5'd0, 12'h304, 32'h22, 5'd0);
        op1(1, 1'b0, 12'h304, 32'h0, 5'd0);
        check("R9 mask priority", bus_rdata[1], 32'h22);
        check("R9 irq", 32'(db_irq), 32'h08);

        // R2 doorbell index out of range
        op1(0, 1'b1, 12'h804, 32'hFF, 5'd0);
        op1(0, 1'b1, 12'h800, 32'h1, 5'd0);
        op1(0, 1'b0, 12'h804, 32'h0, 5'd0);
        check("R2 oor mask", bus_rdata[0], 32'h0);
        op1(0, 1'b0, 12'h808, 32'h0, 5'd0);
        check("R2 oor log", bus_rdata[0], 32'h0);
        check("R2 oor irq", 32'(db_irq), 32'h08);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule